// File: doc/BRIEF.md
# Transmit Holding Empty Interrupt Generator

This block produces the "transmit holding register empty" status and interrupt for a FIFO-mode serial transmitter. It reads the transmit FIFO occupancy from outside and keeps its own empty flag. It raises a pending interrupt when that flag rises. The pending interrupt is cleared when software writes the holding register or reads the interrupt identification register. The interrupt reaches the output only while both the FIFO enable bit and the transmit interrupt enable bit are set.

The empty flag does not always rise at once when the FIFO drains. Suppose the FIFO never held two or more bytes at the same time since the flag last rose. Then the flag waits for one character time less the final stop bit. The block counts this time in bit ticks. The delay is cut short at the start of the final stop bit. It is cancelled if a new byte arrives. After any change of the FIFO enable bit, the next empty indication is given without delay.

Top module: `thre_irq_gen`

## Requirements
- R1: After reset, `thr_empty` is 1 and `tx_irq` is 0.
- R2: `tx_irq` is 1 only while an interrupt is pending and both `fifo_enable` and `tx_int_enable` are 1. Clearing `tx_int_enable` hides a pending interrupt without discarding it.
- R3: A clock edge that sees a nonzero `fifo_level` leaves `thr_empty` at 0.
- R4: If `fifo_level` reached 2 or more since `thr_empty` last rose, `thr_empty` rises on the first edge that sees `fifo_level` equal to 0.
- R5: Otherwise a deferral of L bit ticks starts, where L = `frame_ticks` - `stop_ticks`, saturating at 0. `thr_empty` rises at the edge that takes the L-th `bit_tick`. When L is 0, `thr_empty` rises at once.
- R6: A `final_stop` pulse during a deferral makes `thr_empty` rise at that edge.
- R7: A nonzero `fifo_level` during a deferral cancels it. The next empty period starts a full deferral of L ticks again.
- R8: Each rise of `thr_empty` sets the pending interrupt, unless a clear comes in the same cycle.
- R9: A `thr_write` or `iir_read` pulse clears the pending interrupt. A clear wins over a set in the same cycle.
- R10: A change of `fifo_enable` sets the pending interrupt if `thr_empty` is 1 at that time. It also makes the next rise of `thr_empty` immediate, with no deferral.
- R11: The record of two bytes held together clears when `thr_empty` rises. A later single-byte period is therefore deferred again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_level | input | $clog2(DEPTH+1) | Transmit FIFO occupancy |
| thr_write | input | 1 | Pulse on each write to the holding register |
| iir_read | input | 1 | Pulse on a read of the identification register |
| fifo_enable | input | 1 | FIFO enable control bit |
| tx_int_enable | input | 1 | Transmit interrupt enable bit |
| bit_tick | input | 1 | One pulse per serial bit time |
| final_stop | input | 1 | Pulse at the start of the final stop bit |
| frame_ticks | input | TICK_W | Character length in bit times |
| stop_ticks | input | TICK_W | Final stop bit length in bit times |
| tx_irq | output | 1 | Transmit empty interrupt request |
| thr_empty | output | 1 | Transmit holding empty status |

## Verification
The bench builds the block with its default parameters: a 16-entry occupancy range and 4-bit tick fields. It sets a 10-tick frame with a 1-tick stop, so a deferral lasts 9 ticks. This lets the bench drive the full occupancy of 16 bytes. It also lets it probe the tick just before a deferral ends and the tick that ends it. Changing the frame and stop fields to equal values gives L = 0, which tests the immediate case.

// File: rtl/thre_pkg.sv
package thre_pkg;

    // identification code reported for this source by the priority encoder
    localparam logic [7:0] THRE_SRC_CODE = 8'hC2;

    typedef struct packed {
        logic empty;      // empty indication as seen by software
        logic pair_seen;  // occupancy reached two or more since empty rose
        logic fast_next;  // next empty indication skips the deferral
        logic holding;    // deferral counter running
    } trk_flags_t;

    // deferral length in bit ticks, saturating at zero
    function automatic logic [7:0] defer_span(input logic [7:0] frame,
                                              input logic [7:0] stop);
        return (frame > stop) ? (frame - stop) : 8'd0;
    endfunction

endpackage

// File: rtl/thre_tracker.sv
module thre_tracker
    import thre_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int TICK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  level,
    input  logic              bit_tick,
    input  logic              final_stop,
    input  logic              fen_change,
    input  logic [TICK_W-1:0] frame_ticks,
    input  logic [TICK_W-1:0] stop_ticks,
    output logic              empty,
    output logic              empty_set
);

    trk_flags_t        st_q, st_d;
    logic [TICK_W-1:0] cnt_q, cnt_d;
    logic [TICK_W-1:0] span;
    logic              level_zero;

    assign level_zero = (level == '0);
    assign span       = TICK_W'(defer_span(8'(frame_ticks), 8'(stop_ticks)));

    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        empty_set = 1'b0;
        if (!level_zero) begin
            st_d.empty   = 1'b0;
            st_d.holding = 1'b0;
            if (level >= CNT_W'(2)) st_d.pair_seen = 1'b1;
        end else if (!st_q.empty) begin
            if (st_q.holding) begin
                if (final_stop || (bit_tick && cnt_q <= TICK_W'(1)))
                    empty_set = 1'b1;
                else if (bit_tick)
                    cnt_d = cnt_q - TICK_W'(1);
            end else if (st_q.pair_seen || st_q.fast_next || span == '0) begin
                empty_set = 1'b1;
            end else begin
                st_d.holding = 1'b1;
                cnt_d        = span;
            end
        end
        if (empty_set) begin
            st_d.empty     = 1'b1;
            st_d.holding   = 1'b0;
            st_d.pair_seen = 1'b0;
            st_d.fast_next = 1'b0;
        end
        if (fen_change) st_d.fast_next = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '{empty: 1'b1, pair_seen: 1'b0, fast_next: 1'b0, holding: 1'b0};
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign empty = st_q.empty;

    p_busy_clears_thre_r3: assert property (@(posedge clk) disable iff (rst)
        (level != '0) |=> !empty);

    p_pair_fast_r4: assert property (@(posedge clk) disable iff (rst)
        (!st_q.empty && !st_q.holding && st_q.pair_seen && level == '0) |=> empty);

    p_hold_waits_r5: assert property (@(posedge clk) disable iff (rst)
        (!st_q.empty && st_q.holding && level == '0 && !bit_tick && !final_stop) |=> !empty);

    p_stop_releases_r6: assert property (@(posedge clk) disable iff (rst)
        (!st_q.empty && st_q.holding && level == '0 && final_stop) |=> empty);

endmodule

// File: rtl/thre_irq_latch.sv
module thre_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic empty_set,
    input  logic empty_now,
    input  logic fen_change,
    input  logic thr_write,
    input  logic iir_read,
    output logic pending
);

    logic pend_d;

    always_comb begin
        pend_d = pending;
        if (thr_write || iir_read)
            pend_d = 1'b0;
        else if (empty_set || (fen_change && empty_now))
            pend_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= pend_d;
    end

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (thr_write || iir_read) |=> !pending);

endmodule

// File: rtl/thre_irq_gen.sv
module thre_irq_gen
    import thre_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TICK_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(DEPTH+1)-1:0]   fifo_level,
    input  logic                         thr_write,
    input  logic                         iir_read,
    input  logic                         fifo_enable,
    input  logic                         tx_int_enable,
    input  logic                         bit_tick,
    input  logic                         final_stop,
    input  logic [TICK_W-1:0]            frame_ticks,
    input  logic [TICK_W-1:0]            stop_ticks,
    output logic                         tx_irq,
    output logic                         thr_empty
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic fen_q;
    logic fen_change;
    logic empty_set;
    logic pending;

    always_ff @(posedge clk) begin
        if (rst) fen_q <= 1'b0;
        else     fen_q <= fifo_enable;
    end

    assign fen_change = fifo_enable ^ fen_q;

    thre_tracker #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_tracker (
        .clk         (clk),
        .rst         (rst),
        .level       (fifo_level),
        .bit_tick    (bit_tick),
        .final_stop  (final_stop),
        .fen_change  (fen_change),
        .frame_ticks (frame_ticks),
        .stop_ticks  (stop_ticks),
        .empty       (thr_empty),
        .empty_set   (empty_set)
    );

    thre_irq_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .empty_set  (empty_set),
        .empty_now  (thr_empty),
        .fen_change (fen_change),
        .thr_write  (thr_write),
        .iir_read   (iir_read),
        .pending    (pending)
    );

    assign tx_irq = pending & fifo_enable & tx_int_enable;

    p_rise_pends_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(thr_empty) && !$past(thr_write || iir_read)) |-> pending);

endmodule

// File: tb/test_thre_irq_gen.sv
module test_thre_irq_gen;

    localparam int DEPTH  = 16;
    localparam int TICK_W = 4;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst;
    logic [CNT_W-1:0]  fifo_level;
    logic              thr_write, iir_read, fifo_enable, tx_int_enable;
    logic              bit_tick, final_stop;
    logic [TICK_W-1:0] frame_ticks, stop_ticks;
    logic              tx_irq, thr_empty;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    thre_irq_gen #(.DEPTH(DEPTH), .TICK_W(TICK_W)) i_thre_irq_gen (
        .clk(clk), .rst(rst), .fifo_level(fifo_level), .thr_write(thr_write),
        .iir_read(iir_read), .fifo_enable(fifo_enable), .tx_int_enable(tx_int_enable),
        .bit_tick(bit_tick), .final_stop(final_stop), .frame_ticks(frame_ticks),
        .stop_ticks(stop_ticks), .tx_irq(tx_irq), .thr_empty(thr_empty)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    // one byte written, then drained: deferral begins
    task automatic single_byte();
        thr_write = 1'b1; fifo_level = CNT_W'(1);
        step(1);
        thr_write = 1'b0; fifo_level = '0;
        step(1);
    endtask

    task automatic t_reset();
        rst = 1'b1; fifo_level = '0; thr_write = 0; iir_read = 0;
        fifo_enable = 0; tx_int_enable = 0; bit_tick = 0; final_stop = 0;
        frame_ticks = 4'd10; stop_ticks = 4'd1;
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 empty after reset", thr_empty, 1'b1);
        check("R1 irq after reset", tx_irq, 1'b0);
    endtask

    task automatic t_enable_change();
        tx_int_enable = 1'b1; fifo_enable = 1'b1;
        step(1);
        check("R10 change with empty set pends", tx_irq, 1'b1);
        tx_int_enable = 1'b0;
        step(1);
        check("R2 irq hidden when disabled", tx_irq, 1'b0);
        tx_int_enable = 1'b1;
        step(1);
        check("R2 pending kept while hidden", tx_irq, 1'b1);
        iir_read = 1'b1;
        step(1);
        iir_read = 1'b0;
        check("R9 identification read clears", tx_irq, 1'b0);
    endtask

    task automatic t_fast_after_change();
        thr_write = 1'b1; fifo_level = CNT_W'(1);
        step(1);
        thr_write = 1'b0;
        check("R3 empty drops with data", thr_empty, 1'b0);
        fifo_level = '0;
        step(1);
        check("R10 first empty after change immediate", thr_empty, 1'b1);
        check("R8 rise pends interrupt", tx_irq, 1'b1);
    endtask

    task automatic t_defer();
        single_byte();
        check("R5 empty held at deferral start", thr_empty, 1'b0);
        tick(8);
        check("R5 empty held before last tick", thr_empty, 1'b0);
        check("R9 write cleared pending", tx_irq, 1'b0);
        tick(1);
        check("R5 empty at ninth tick", thr_empty, 1'b1);
        check("R8 deferred rise pends", tx_irq, 1'b1);
    endtask

    task automatic t_pair();
        thr_write = 1'b1; fifo_level = CNT_W'(1);
        step(1);
        fifo_level = CNT_W'(16);
        step(1);
        thr_write = 1'b0; fifo_level = CNT_W'(1);
        step(1);
        fifo_level = '0;
        step(1);
        check("R4 empty immediate after full FIFO", thr_empty, 1'b1);
        check("R8 immediate rise pends", tx_irq, 1'b1);
    endtask

    task automatic t_sticky_cleared();
        single_byte();
        check("R11 single byte after pair defers", thr_empty, 1'b0);
        tick(9);
        check("R11 deferral completes", thr_empty, 1'b1);
    endtask

    task automatic t_cancel();
        single_byte();
        tick(5);
        fifo_level = CNT_W'(1); thr_write = 1'b1;
        step(1);
        thr_write = 1'b0; fifo_level = '0;
        step(1);
        tick(8);
        check("R7 cancelled deferral reloads full span", thr_empty, 1'b0);
        tick(1);
        check("R7 reloaded span expires", thr_empty, 1'b1);
    endtask

    task automatic t_stop_release();
        single_byte();
        tick(2);
        final_stop = 1'b1;
        step(1);
        final_stop = 1'b0;
        check("R6 final stop releases early", thr_empty, 1'b1);
        check("R8 early rise pends", tx_irq, 1'b1);
    endtask

    task automatic t_zero_span();
        frame_ticks = 4'd2; stop_ticks = 4'd2;
        single_byte();
        check("R5 zero span immediate", thr_empty, 1'b1);
        frame_ticks = 4'd10; stop_ticks = 4'd1;
    endtask

    task automatic t_clear_wins();
        // pending is set; a write clears it
        check("R9 pending before write", tx_irq, 1'b1);
        thr_write = 1'b1; fifo_level = CNT_W'(1);
        step(1);
        thr_write = 1'b0;
        check("R9 write clears pending", tx_irq, 1'b0);
        fifo_level = '0;
        step(1);
    endtask

    initial begin
        t_reset();
        t_enable_change();
        t_fast_after_change();
        t_defer();
        t_pair();
        t_sticky_cleared();
        t_cancel();
        t_stop_release();
        t_zero_span();
        t_clear_wins();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(20000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule